// File: doc/BRIEF.md
# Departure Slot Assigner for a Shared-Buffer Router

This block decides, for every flit arriving at a shared-buffer router, the future cycle in which the flit will leave. It keeps a short look-ahead window of departure slots. For each slot and each out-port it holds a count of the flits already booked. Each cycle, up to `NUM_IN` new flits and up to `NUM_IN` returning flits present a destination out-port. Returning flits are flits that buffer allocation could not place. Each request is answered in the same cycle, either with a slot offset or with a refusal.

An out-port may carry a different number of flits per cycle from the others. These per-port egress widths are parameters. A slot offset of 0 names the departure slot now at the head of the window. On every clock edge the window moves forward by one slot: offset k becomes offset k-1, and an empty slot enters at the far end.

Top module: `depart_stamper`

## Requirements
- R1: After reset every slot of every out-port is empty: with no requests no grant is given, and the first request to any port is granted offset 0.
- R2: Within any one slot, the number of flits booked for out-port p never exceeds that port's egress width. This holds across cycles as bookings move toward offset 0.
- R3: A granted request receives the lowest offset that still has room for its out-port, taking into account grants made earlier in the same cycle.
- R4: Within a cycle, requests are served in a fixed order. All returning requests (`retry_*`) come first, by index from 0 upward, then all fresh requests (`req_*`), by index from 0 upward.
- R5: On each clock edge the bookings at offset k move to offset k-1, the bookings at offset 0 are dropped, and offset WINDOW-1 starts empty.
- R6: When every slot in the window is full for the requested out-port, the request gets no grant and books nothing. Requests to other ports are unaffected.
- R7: A request naming a port number of NUM_OUT or more gets no grant and books nothing.
- R8: The egress widths are per-port parameters, packed CAP_W bits per port with port 0 in the lowest bits. The defaults are 2 for port 0, 1 for port 1 and 3 for port 2.
- R9: Grant bits and offsets are combinational in the cycle of the request. Offset r sits in bits [r*SLOT_W +: SLOT_W], and port r in bits [r*PORT_W +: PORT_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | NUM_IN | Fresh request valid per ingress lane |
| req_port | input | NUM_IN*PORT_W | Destination out-port per fresh request |
| retry_vld | input | NUM_IN | Returning request valid per lane |
| retry_port | input | NUM_IN*PORT_W | Destination out-port per returning request |
| req_gnt | output | NUM_IN | Fresh request granted |
| req_slot | output | NUM_IN*SLOT_W | Offset granted to each fresh request |
| retry_gnt | output | NUM_IN | Returning request granted |
| retry_slot | output | NUM_IN*SLOT_W | Offset granted to each returning request |

## Verification
The bench places several same-port requests in one cycle. A design that did not count grants made earlier in that cycle would hand two flits the same slot past the port's width. The same kind of design would show flits bunched at offset 0 on the narrow port. The bench books slots, lets the window advance, and then requests again. An off-by-one shift would show up as a stamp one slot early or late, and so would a stale newest slot. Tests also fill the whole window of the one-wide port, mix in a returning flit, and send an illegal port number. These cases expose a design that grants beyond the window, that serves fresh requests ahead of returning ones, or that books a slot for a port that does not exist.

// File: rtl/depart_stamper.sv
module depart_stamper #(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 3,
  parameter int WINDOW  = 8,
  parameter int CAP_W   = 3,
  parameter logic [NUM_OUT*CAP_W-1:0] ELW_VEC = {3'd3, 3'd1, 3'd2},
  localparam int PORT_W = (NUM_OUT > 1) ? $clog2(NUM_OUT + 1) : 1,
  localparam int SLOT_W = (WINDOW > 1) ? $clog2(WINDOW) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_IN-1:0]        req_vld,
  input  logic [NUM_IN*PORT_W-1:0] req_port,
  input  logic [NUM_IN-1:0]        retry_vld,
  input  logic [NUM_IN*PORT_W-1:0] retry_port,
  output logic [NUM_IN-1:0]        req_gnt,
  output logic [NUM_IN*SLOT_W-1:0] req_slot,
  output logic [NUM_IN-1:0]        retry_gnt,
  output logic [NUM_IN*SLOT_W-1:0] retry_slot
);
  localparam int NREQ = 2 * NUM_IN;

  logic [CAP_W-1:0]  occ  [WINDOW][NUM_OUT];
  logic [CAP_W-1:0]  cnt  [WINDOW][NUM_OUT];
  logic              all_vld  [NREQ];
  logic [PORT_W-1:0] all_port [NREQ];
  logic              all_gnt  [NREQ];
  logic [SLOT_W-1:0] all_slot [NREQ];

  function automatic logic [CAP_W-1:0] cap_of(int p);
    return ELW_VEC[p*CAP_W +: CAP_W];
  endfunction

  for (genvar i = 0; i < NUM_IN; i++) begin : g_lane
    assign all_vld[i]          = retry_vld[i];
    assign all_port[i]         = retry_port[i*PORT_W +: PORT_W];
    assign all_vld[NUM_IN+i]   = req_vld[i];
    assign all_port[NUM_IN+i]  = req_port[i*PORT_W +: PORT_W];
    assign retry_gnt[i]                = all_gnt[i];
    assign retry_slot[i*SLOT_W +: SLOT_W] = all_slot[i];
    assign req_gnt[i]                  = all_gnt[NUM_IN+i];
    assign req_slot[i*SLOT_W +: SLOT_W]   = all_slot[NUM_IN+i];
  end

  always_comb begin
    cnt = occ;
    for (int r = 0; r < NREQ; r++) begin
      all_gnt[r]  = 1'b0;
      all_slot[r] = '0;
      if (all_vld[r] && (int'(all_port[r]) < NUM_OUT)) begin
        for (int k = 0; k < WINDOW; k++) begin
          if (!all_gnt[r] && (cnt[k][int'(all_port[r])] < cap_of(int'(all_port[r])))) begin
            all_gnt[r]  = 1'b1;
            all_slot[r] = SLOT_W'(k);
            cnt[k][int'(all_port[r])] = cnt[k][int'(all_port[r])] + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < WINDOW; k++)
        for (int p = 0; p < NUM_OUT; p++)
          occ[k][p] <= '0;
    end else begin
      for (int k = 0; k < WINDOW - 1; k++)
        occ[k] <= cnt[k+1];
      for (int p = 0; p < NUM_OUT; p++)
        occ[WINDOW-1][p] <= '0;
    end
  end

  for (genvar k = 0; k < WINDOW; k++) begin : g_chk_slot
    for (genvar p = 0; p < NUM_OUT; p++) begin : g_chk_port
      p_slot_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        occ[k][p] <= ELW_VEC[p*CAP_W +: CAP_W]);
      if (k > 0) begin : g_shift
        p_window_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
          rst_n && $past(rst_n) |-> occ[k-1][p] >= $past(occ[k][p]));
      end
    end
  end

  for (genvar r = 0; r < NREQ; r++) begin : g_chk_req
    p_gnt_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      all_gnt[r] |-> (all_vld[r] && (int'(all_port[r]) < NUM_OUT)));
  end

  for (genvar a = 0; a < NUM_IN; a++) begin : g_chk_rt
    for (genvar f = 0; f < NUM_IN; f++) begin : g_chk_fr
      p_retry_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(retry_vld[a] && !retry_gnt[a] && req_gnt[f] &&
          retry_port[a*PORT_W +: PORT_W] == req_port[f*PORT_W +: PORT_W]));
    end
  end
endmodule

// File: tb/depart_stamper_tb_top.sv
module depart_stamper_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 4;
  localparam int PW = 2;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NI-1:0]    req_vld, retry_vld;
  logic [NI*PW-1:0] req_port, retry_port;
  logic [NI-1:0]    req_gnt, retry_gnt;
  logic [NI*SW-1:0] req_slot, retry_slot;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  depart_stamper dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_vld(req_vld), .req_port(req_port),
    .retry_vld(retry_vld), .retry_port(retry_port),
    .req_gnt(req_gnt), .req_slot(req_slot),
    .retry_gnt(retry_gnt), .retry_slot(retry_slot)
  );

  task automatic clear_in();
    req_vld = '0; retry_vld = '0; req_port = '0; retry_port = '0;
  endtask

  task automatic do_reset();
    clear_in();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic fresh(int i, int p);
    req_vld[i] = 1'b1;
    req_port[i*PW +: PW] = PW'(p);
  endtask

  task automatic retry(int i, int p);
    retry_vld[i] = 1'b1;
    retry_port[i*PW +: PW] = PW'(p);
  endtask

  task automatic next_cycle();
    @(negedge clk);
    clear_in();
  endtask

  task automatic chk(string tag, bit is_retry, int i, bit eg, int es);
    logic g;
    int s;
    g = is_retry ? retry_gnt[i] : req_gnt[i];
    s = is_retry ? int'(retry_slot[i*SW +: SW]) : int'(req_slot[i*SW +: SW]);
    checks++;
    if (g !== eg || (eg && s != es)) begin
      errors++;
      $display("FAIL %s %s[%0d]: got gnt=%0b slot=%0d, expected gnt=%0b slot=%0d",
               tag, is_retry ? "retry" : "req", i, g, s, eg, es);
    end
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    for (int i = 0; i < NI; i++) chk("R1 idle", 0, i, 0, 0);
    fresh(2, 1);
    #1;
    chk("R1/R9 first", 0, 2, 1, 0);
    next_cycle();
  endtask

  task automatic t_widths();
    do_reset();
    for (int i = 0; i < NI; i++) fresh(i, 0);
    #1;
    chk("R8/R3 p0", 0, 0, 1, 0); chk("R8/R3 p0", 0, 1, 1, 0);
    chk("R8/R3 p0", 0, 2, 1, 1); chk("R8/R3 p0", 0, 3, 1, 1);
    do_reset();
    for (int i = 0; i < NI; i++) fresh(i, 1);
    #1;
    for (int i = 0; i < NI; i++) chk("R8/R3 p1", 0, i, 1, i);
    do_reset();
    for (int i = 0; i < NI; i++) fresh(i, 2);
    #1;
    chk("R8/R3 p2", 0, 0, 1, 0); chk("R8/R3 p2", 0, 1, 1, 0);
    chk("R8/R3 p2", 0, 2, 1, 0); chk("R8/R3 p2", 0, 3, 1, 1);
    next_cycle();
  endtask

  task automatic t_order();
    do_reset();
    fresh(0, 1); retry(3, 1);
    #1;
    chk("R4 retry first", 1, 3, 1, 0);
    chk("R4 fresh after", 0, 0, 1, 1);
    do_reset();
    fresh(3, 1); fresh(1, 1);
    #1;
    chk("R4 low index", 0, 1, 1, 0);
    chk("R4 high index", 0, 3, 1, 1);
    next_cycle();
  endtask

  task automatic t_advance();
    do_reset();
    for (int i = 0; i < NI; i++) fresh(i, 1);
    next_cycle();
    fresh(0, 1);
    #1;
    chk("R5 shift one", 0, 0, 1, 3);
    next_cycle();
    next_cycle();
    fresh(0, 1);
    #1;
    chk("R5 shift two", 0, 0, 1, 2);
    next_cycle();
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < NI; i++) begin fresh(i, 1); retry(i, 1); end
    #1;
    for (int i = 0; i < NI; i++) chk("R6 fill retry", 1, i, 1, i);
    for (int i = 0; i < NI; i++) chk("R6 fill fresh", 0, i, 1, NI + i);
    next_cycle();
    fresh(0, 1); fresh(1, 1); fresh(2, 0);
    #1;
    chk("R6 newest slot", 0, 0, 1, 7);
    chk("R6 no room", 0, 1, 0, 0);
    chk("R6 other port", 0, 2, 1, 0);
    next_cycle();
    fresh(1, 1);
    #1;
    chk("R6 refill newest", 0, 1, 1, 7);
    next_cycle();
  endtask

  task automatic t_badport();
    do_reset();
    fresh(0, 3); fresh(1, 1);
    #1;
    chk("R7 bad port", 0, 0, 0, 0);
    chk("R7 neighbour", 0, 1, 1, 0);
    next_cycle();
    fresh(2, 1);
    #1;
    chk("R7 no booking", 0, 2, 1, 0);
    next_cycle();
  endtask

  task automatic t_carry();
    do_reset();
    for (int i = 0; i < NI; i++) fresh(i, 2);
    next_cycle();
    fresh(0, 2); fresh(1, 2); fresh(2, 2);
    #1;
    chk("R2 carried", 0, 0, 1, 0);
    chk("R2 carried", 0, 1, 1, 0);
    chk("R2 carried", 0, 2, 1, 1);
    next_cycle();
  endtask

  initial begin
    clear_in();
    t_reset();
    t_widths();
    t_order();
    t_advance();
    t_full();
    t_badport();
    t_carry();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule